// File: doc/BRIEF.md
# Ownership-Handoff Mailbox

This block is a device-side mailbox: a 256-bit window that a requester sees as eight 32-bit words. The requester fills the lower words with a message, then writes the last word, which carries the control header. That final write passes the mailbox to a responder. The block sets the owner flag, bit 31 of the last word, and raises a one-cycle request-valid pulse. During that pulse the whole 256-bit contents are shown on the responder port.

The responder reads the latched message and answers through a single strobe. The strobe loads a new header into bits [30:0] of the last word and clears the owner flag in the same cycle, which gives the mailbox back to the requester. The requester polls bit 31 to learn who owns the window. In a response header, bits [2:0] repeat the request type, bit 7 is 1, and bits [15:8] carry the status, where 0 means success. The block stores these bits but does not interpret them.

A requester-reset input forces every requester read to return all ones, so software can tell that a reset happened. The stored contents are not changed by it.

Top module: `mbox_handoff`

## Requirements
- R1: After synchronous reset, all eight words read as zero, `rsp_owns` is 0 and `rsp_req_valid` is 0.
- R2: While the requester owns the mailbox (`rsp_owns`=0), a requester write to word 0..6 stores the data at that word. `rq_rdata` shows the word selected by `rq_addr` in the same cycle, with no register stage.
- R3: A requester write to word 7 while `rsp_owns`=0 stores `rq_wdata[30:0]` into bits [30:0] of word 7. From the next cycle, bit 31 of word 7 and `rsp_owns` are 1, whatever value `rq_wdata[31]` had.
- R4: In the cycle after an accepted write to word 7, `rsp_req_valid` is 1 for exactly one cycle. `rsp_msg` always presents word i at bits [32i+31:32i].
- R5: While `rsp_owns`=1, requester writes to any word, including word 7, are ignored and raise no further pulse.
- R6: While `rsp_owns`=1, `rsp_wr_en` loads `rsp_hdr` into bits [30:0] of word 7 and clears bit 31 and `rsp_owns` from the next cycle. Words 0..6 are left unchanged.
- R7: While `rsp_owns`=0, `rsp_wr_en` has no effect.
- R8: While `rq_in_reset`=1, `rq_rdata` is 0xFFFFFFFF for every address. The stored words are untouched and read back normally once the input drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rq_in_reset | input | 1 | Requester-reset condition; forces reads to all ones |
| rq_addr | input | 3 | Requester word index for read and write |
| rq_wr_en | input | 1 | Requester write strobe |
| rq_wdata | input | 32 | Requester write data |
| rq_rdata | output | 32 | Requester read data for `rq_addr` |
| rsp_req_valid | output | 1 | One-cycle pulse when ownership passes to the responder |
| rsp_msg | output | 256 | Full mailbox contents |
| rsp_owns | output | 1 | Owner flag (bit 31 of word 7) |
| rsp_wr_en | input | 1 | Responder header write and release strobe |
| rsp_hdr | input | 31 | Response header for bits [30:0] of word 7 |

## Verification
A requester write and a responder write can arrive in the same cycle, and only the current owner may act. The bench drives both strobes together in both ownership states. It does this with a write to word 7 while the requester owns the mailbox, and with a write to a lower word and to word 7 while the responder owns it. Each cycle, a behavioural reference model decides which write takes effect. All 256 bits, the owner flag, the pulse and the read data are then compared against it, so a design that lets the wrong side through, or both, shows up in the cycle after the clash.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int WORD_W = 32;

    // Layout of the last word; the owner flag is the top bit.
    typedef struct packed {
        logic       owner;
        logic [5:0] rsvd_hi;
        logic       rq_reset_flag;
        logic [7:0] rsvd_mid;
        logic [7:0] status;
        logic       dir;
        logic       rsvd_lo;
        logic [2:0] version;
        logic [2:0] mtype;
    } ctl_word_t;

    function automatic ctl_word_t seal_ctl(input logic [WORD_W-2:0] body, input logic own);
        return ctl_word_t'({own, body});
    endfunction

endpackage

// File: rtl/mbox_owner.sv
module mbox_owner (
    input  logic clk,
    input  logic rst,
    input  logic claim_req,
    input  logic release_req,
    output logic owned,
    output logic claim_grant,
    output logic release_grant,
    output logic req_pulse
);
    logic owned_q;
    logic pulse_q;

    assign claim_grant   = claim_req && !owned_q;
    assign release_grant = release_req && owned_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            owned_q <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= claim_grant;
            if (claim_grant)
                owned_q <= 1'b1;
            else if (release_grant)
                owned_q <= 1'b0;
        end
    end

    assign owned     = owned_q;
    assign req_pulse = pulse_q;

    assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!owned && !req_pulse));
    assert_claim_R3: assert property (@(posedge clk) disable iff (rst)
        (claim_req && !owned) |=> (owned && req_pulse));
    assert_pulse_once_R4: assert property (@(posedge clk) disable iff (rst)
        req_pulse |=> !req_pulse);
    assert_release_R6: assert property (@(posedge clk) disable iff (rst)
        (release_req && owned) |=> !owned);
    assert_no_release_R7: assert property (@(posedge clk) disable iff (rst)
        (release_req && !owned && !claim_req) |=> !owned);

endmodule

// File: rtl/mbox_store.sv
module mbox_store
    import mbox_pkg::*;
#(
    parameter int N_DW  = 8,
    parameter int IDX_W = $clog2(N_DW)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_grant,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic                     ctl_grant,
    input  logic [WORD_W-2:0]        ctl_body,
    input  logic                     owner,
    output logic [N_DW*WORD_W-1:0]   words
);
    localparam int LAST = N_DW - 1;

    for (genvar i = 0; i < N_DW; i++) begin : g_word
        if (i == LAST) begin : g_ctl
            logic [WORD_W-2:0] body_q;
            ctl_word_t         view;
            always_ff @(posedge clk) begin
                if (rst)
                    body_q <= '0;
                else if (wr_grant && wr_idx == IDX_W'(i))
                    body_q <= wr_data[WORD_W-2:0];
                else if (ctl_grant)
                    body_q <= ctl_body;
            end
            assign view = seal_ctl(body_q, owner);
            assign words[i*WORD_W +: WORD_W] = view;
        end else begin : g_data
            logic [WORD_W-1:0] data_q;
            always_ff @(posedge clk) begin
                if (rst)
                    data_q <= '0;
                else if (wr_grant && wr_idx == IDX_W'(i))
                    data_q <= wr_data;
            end
            assign words[i*WORD_W +: WORD_W] = data_q;
        end
    end

endmodule

// File: rtl/mbox_rdmux.sv
module mbox_rdmux
    import mbox_pkg::*;
#(
    parameter int N_DW  = 8,
    parameter int IDX_W = $clog2(N_DW)
) (
    input  logic [N_DW*WORD_W-1:0] words,
    input  logic [IDX_W-1:0]       idx,
    input  logic                   force_ones,
    output logic [WORD_W-1:0]      rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_DW; i++)
            if (idx == IDX_W'(i))
                rdata = words[i*WORD_W +: WORD_W];
        if (force_ones)
            rdata = '1;
    end

endmodule

// File: rtl/mbox_handoff.sv
module mbox_handoff
    import mbox_pkg::*;
#(
    parameter  int N_DW  = 8,
    localparam int IDX_W = $clog2(N_DW),
    localparam int MSG_W = N_DW * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rq_in_reset,
    input  logic [IDX_W-1:0]  rq_addr,
    input  logic              rq_wr_en,
    input  logic [WORD_W-1:0] rq_wdata,
    output logic [WORD_W-1:0] rq_rdata,
    output logic              rsp_req_valid,
    output logic [MSG_W-1:0]  rsp_msg,
    output logic              rsp_owns,
    input  logic              rsp_wr_en,
    input  logic [WORD_W-2:0] rsp_hdr
);
    localparam int LAST = N_DW - 1;

    logic owned, claim_grant, release_grant, req_pulse;
    logic rq_grant;
    logic hits_last;
    logic [MSG_W-1:0] words;

    assign hits_last = (rq_addr == IDX_W'(LAST));

    mbox_owner u_owner (
        .clk          (clk),
        .rst          (rst),
        .claim_req    (rq_wr_en && hits_last),
        .release_req  (rsp_wr_en),
        .owned        (owned),
        .claim_grant  (claim_grant),
        .release_grant(release_grant),
        .req_pulse    (req_pulse)
    );

    // Lower words share the owner gate with the handoff word.
    assign rq_grant = rq_wr_en && !owned;

    mbox_store #(.N_DW(N_DW), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_grant (rq_grant),
        .wr_idx   (rq_addr),
        .wr_data  (rq_wdata),
        .ctl_grant(release_grant),
        .ctl_body (rsp_hdr),
        .owner    (owned),
        .words    (words)
    );

    mbox_rdmux #(.N_DW(N_DW), .IDX_W(IDX_W)) u_rdmux (
        .words     (words),
        .idx       (rq_addr),
        .force_ones(rq_in_reset),
        .rdata     (rq_rdata)
    );

    assign rsp_msg       = words;
    assign rsp_owns      = owned;
    assign rsp_req_valid = req_pulse;

    assert_locked_R5: assert property (@(posedge clk) disable iff (rst)
        (rq_wr_en && owned) |=> $stable(rsp_msg[LAST*WORD_W-1:0]));
    assert_hdr_load_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_wr_en && owned) |=> (rsp_msg[MSG_W-2 -: WORD_W-1] == $past(rsp_hdr)));
    assert_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_wr_en && !owned && !rq_wr_en) |=> $stable(rsp_msg));
    assert_flag_bit_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_msg[MSG_W-1] == rsp_owns);

endmodule

// File: tb/tb_mbox_handoff.sv
module tb_mbox_handoff;

    logic         clk = 1'b0;
    logic         rst;
    logic         rq_in_reset;
    logic [2:0]   rq_addr;
    logic         rq_wr_en;
    logic [31:0]  rq_wdata;
    logic [31:0]  rq_rdata;
    logic         rsp_req_valid;
    logic [255:0] rsp_msg;
    logic         rsp_owns;
    logic         rsp_wr_en;
    logic [30:0]  rsp_hdr;

    int checks = 0;
    int errors = 0;

    logic [31:0] m [8];
    logic        m_own;
    logic        m_pulse;

    always #5 clk = ~clk;

    mbox_handoff dut (
        .clk          (clk),
        .rst          (rst),
        .rq_in_reset  (rq_in_reset),
        .rq_addr      (rq_addr),
        .rq_wr_en     (rq_wr_en),
        .rq_wdata     (rq_wdata),
        .rq_rdata     (rq_rdata),
        .rsp_req_valid(rsp_req_valid),
        .rsp_msg      (rsp_msg),
        .rsp_owns     (rsp_owns),
        .rsp_wr_en    (rsp_wr_en),
        .rsp_hdr      (rsp_hdr)
    );

    task automatic check(input string tag, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference update at the clock edge, from the values before the edge.
    task automatic model_edge();
        if (rst) begin
            for (int i = 0; i < 8; i++) m[i] = '0;
            m_own = 1'b0;
            m_pulse = 1'b0;
        end else begin
            m_pulse = 1'b0;
            if (rq_wr_en && !m_own) begin
                if (rq_addr == 3'd7) begin
                    m[7] = {1'b1, rq_wdata[30:0]};
                    m_own = 1'b1;
                    m_pulse = 1'b1;
                end else begin
                    m[rq_addr] = rq_wdata;
                end
            end else if (rsp_wr_en && m_own) begin
                m[7] = {1'b0, rsp_hdr};
                m_own = 1'b0;
            end
        end
    endtask

    task automatic compare(input string tag);
        logic [255:0] exp_msg;
        logic [31:0]  exp_rd;
        for (int i = 0; i < 8; i++) exp_msg[i*32 +: 32] = m[i];
        exp_rd = rq_in_reset ? 32'hFFFF_FFFF : m[rq_addr];
        check(tag, "rq_rdata", 256'(rq_rdata), 256'(exp_rd));
        check(tag, "rsp_msg", rsp_msg, exp_msg);
        check(tag, "rsp_owns", 256'(rsp_owns), 256'(m_own));
        check(tag, "rsp_req_valid", 256'(rsp_req_valid), 256'(m_pulse));
    endtask

    // One cycle: drive at the falling edge, let the model follow the rising edge,
    // compare at the next falling edge.
    task automatic cyc(input string tag, input logic w, input logic [2:0] a,
                       input logic [31:0] d, input logic rw, input logic [30:0] h,
                       input logic rr);
        rq_wr_en = w; rq_addr = a; rq_wdata = d;
        rsp_wr_en = rw; rsp_hdr = h; rq_in_reset = rr;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input string tag, input logic [2:0] a, input logic rr);
        cyc(tag, 1'b0, a, 32'h0, 1'b0, 31'h0, rr);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m[i] = 32'hDEAD_0000;
        m_own = 1'b1; m_pulse = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        idle("R1", 3'd0, 1'b0);
        idle("R1", 3'd7, 1'b0);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) idle("R1", 3'(i), 1'b0);

        // R2: fill the lower words with distinct patterns.
        for (int i = 0; i < 7; i++)
            cyc("R2", 1'b1, 3'(i), 32'hA5A5_0000 ^ (32'h1111_1111 * i), 1'b0, 31'h0, 1'b0);
        for (int i = 0; i < 7; i++) idle("R2", 3'(i), 1'b0);
        cyc("R2", 1'b1, 3'd3, 32'hFFFF_0001, 1'b0, 31'h0, 1'b0);

        // R8: all ones while requester reset is active, contents kept.
        for (int i = 0; i < 8; i++) idle("R8", 3'(i), 1'b1);
        idle("R8", 3'd3, 1'b0);

        // R3/R4: handoff write with bit 31 clear in the data; the model sets it.
        cyc("R3", 1'b1, 3'd7, 32'h0100_0001, 1'b0, 31'h0, 1'b0);
        idle("R4", 3'd7, 1'b0);
        idle("R4", 3'd7, 1'b0);

        // R5: requester writes while the responder owns the mailbox.
        cyc("R5", 1'b1, 3'd2, 32'h1234_5678, 1'b0, 31'h0, 1'b0);
        cyc("R5", 1'b1, 3'd7, 32'h8000_0042, 1'b0, 31'h0, 1'b0);
        idle("R5", 3'd2, 1'b0);
        idle("R8", 3'd7, 1'b1);

        // R6 with a clashing requester write in the same cycle.
        cyc("R6", 1'b1, 3'd5, 32'hCAFE_F00D, 1'b1, 31'h0000_0181, 1'b0);
        idle("R6", 3'd7, 1'b0);
        idle("R6", 3'd5, 1'b0);

        // R7: responder strobe while the requester owns the mailbox.
        cyc("R7", 1'b0, 3'd7, 32'h0, 1'b1, 31'h7FFF_FFFF, 1'b0);
        idle("R7", 3'd7, 1'b0);

        // Clash while the requester owns it: the handoff wins, the response is dropped.
        cyc("R7", 1'b1, 3'd7, 32'hFFFF_FF02, 1'b1, 31'h0000_0282, 1'b0);
        idle("R4", 3'd7, 1'b0);
        cyc("R6", 1'b1, 3'd7, 32'h0, 1'b1, 31'h0100_0382, 1'b0);
        idle("R6", 3'd7, 1'b0);

        // Back-to-back round with new contents.
        cyc("R2", 1'b1, 3'd0, 32'h0BAD_BEEF, 1'b0, 31'h0, 1'b0);
        cyc("R3", 1'b1, 3'd7, 32'h0000_0009, 1'b0, 31'h0, 1'b0);
        cyc("R6", 1'b0, 3'd0, 32'h0, 1'b1, 31'h0000_0189, 1'b0);
        cyc("R3", 1'b1, 3'd7, 32'h0000_000A, 1'b0, 31'h0, 1'b0);
        idle("R4", 3'd0, 1'b0);

        rst = 1'b1;
        idle("R1", 3'd7, 1'b0);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) idle("R1", 3'(i), 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule